// File: doc/BRIEF.md
# Multi-Mode Position Counter Core

This block is a 32-bit up/down position counter. It is meant to sit behind a quadrature decoder and a register file. Each count request arrives as a single-cycle enable together with a direction bit.

Four count modes shape how the counter treats its ends:
- wrapping freely;
- stopping itself after the first wrap;
- clamping between zero and a programmable ceiling;
- cycling modulo N+1.

The ceiling, the modulus and the target position all come from one data-register input. The block raises carry, borrow, compare and index events and keeps them as sticky status bits. It also tracks a sign bit.

Clear, load and snapshot commands can come from the register side or from an active-low index input. Two flag outputs report the state:
- Flag A is active low. It merges the masked events, either latched or as a one-cycle pulse.
- Flag B shows the sign or the direction.

The counter itself is not a port. The register side reads it through the snapshot register.

Top module: `pos_count_core`

## Requirements
- R1: After reset the following hold: counter 0, snapshot 0, all four status bits 0, sign 0, direction 1 (up), count_active 1, flag_a_n 1, flag_b 1.
- R2: With cnt_mode 00 (free-running), each cnt_en pulse moves the counter by one in the direction of cnt_up. Going up from all ones wraps to 0 and sets st_carry. Going down from 0 wraps to all ones and sets st_borrow.
- R3: With cnt_mode 01 (single-cycle), a carry or borrow wrap drops count_active and ignores further count pulses. Counting comes back only after a clear or a load.
- R4: With cnt_mode 10 (range-limit), an up pulse at counter equal to data_reg has no effect, and a down pulse at 0 has no effect. A pulse in the opposite direction counts normally.
- R5: With cnt_mode 11 (modulo-N), an up pulse at counter equal to N (data_reg) gives 0 and sets st_carry. A down pulse at 0 gives N and sets st_borrow.
- R6: A count step that lands on data_reg sets st_cmp. Under modes 00 and 01 this holds in both directions; under modes 10 and 11 it holds only for up steps.
- R7: While cnt_inhibit is 1, count_active is 0 and count pulses leave the counter unchanged.
- R8: A falling edge on the active-low index_n acts according to idx_func: 00 does nothing at all, 01 loads data_reg, 10 clears the counter, 11 copies the counter into the snapshot. For codes 01 to 11 the edge also sets st_idx. Holding index_n low does not repeat the action.
- R9: Command priority is as follows. Clear beats load, and either one drops a count pulse in the same cycle. A snapshot captures the counter value from before that cycle's count.
- R10: flga_mask selects the events that drive flag A: bit 0 carry, bit 1 borrow, bit 2 compare, bit 3 index. With flga_pulsed 0, flag_a_n is low while any enabled status bit is set, and cmd_stat_clr releases it. With flga_pulsed 1, flag_a_n is low for exactly the one cycle after the event.
- R11: flgb_sel selects flag B: 01 shows the sign, 10 shows the direction of the latest count pulse (1 = up), and 00 or 11 hold it at 1.
- R12: A borrow sets the sign and a carry clears it, and these events override cmd_sign_set and cmd_sign_clr in the same cycle. cmd_stat_clr clears the four status bits and leaves sign and direction untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | One-cycle count request |
| cnt_up | input | 1 | Direction of the request, 1 = up |
| cnt_mode | input | 2 | 00 free, 01 single-cycle, 10 range-limit, 11 modulo-N |
| idx_func | input | 2 | Index action: 00 none, 01 load, 10 clear, 11 snapshot |
| flgb_sel | input | 2 | Flag B source select |
| cnt_inhibit | input | 1 | Blocks counting while 1 |
| flga_mask | input | 4 | Flag A event enables |
| flga_pulsed | input | 1 | 1 = pulsed flag A, 0 = latched |
| data_reg | input | W | Limit, modulus or target value |
| index_n | input | 1 | Active-low index input |
| cmd_clear | input | 1 | Clear counter |
| cmd_load | input | 1 | Load counter from data_reg |
| cmd_snap | input | 1 | Copy counter to snapshot |
| cmd_stat_clr | input | 1 | Clear sticky status bits |
| cmd_sign_set | input | 1 | Set sign bit |
| cmd_sign_clr | input | 1 | Clear sign bit |
| snap_q | output | W | Snapshot register |
| st_carry | output | 1 | Sticky carry status |
| st_borrow | output | 1 | Sticky borrow status |
| st_cmp | output | 1 | Sticky compare status |
| st_idx | output | 1 | Sticky index status |
| sign_q | output | 1 | Sign bit |
| dir_up_q | output | 1 | Direction of latest count pulse |
| count_active | output | 1 | Counting currently permitted |
| flag_a_n | output | 1 | Active-low merged event flag |
| flag_b | output | 1 | Sign or direction flag |

## Verification
The hardest states to reach are the wraps at the ends of a 32-bit range. The most difficult is the single-cycle halt, which needs the counter to sit at all ones or at zero before a pulse arrives. The stimulus gets there by loading an edge value from data_reg rather than issuing billions of count pulses. It then checks the halt by issuing extra pulses and reading the frozen value through a snapshot. The range and modulo modes use a small data_reg, so both clamps, both wraps and the direction-dependent compare are reached within a few pulses.

// File: rtl/pos_count_core.sv
module pos_count_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         cnt_up,
  input  logic [1:0]   cnt_mode,
  input  logic [1:0]   idx_func,
  input  logic [1:0]   flgb_sel,
  input  logic         cnt_inhibit,
  input  logic [3:0]   flga_mask,
  input  logic         flga_pulsed,
  input  logic [W-1:0] data_reg,
  input  logic         index_n,
  input  logic         cmd_clear,
  input  logic         cmd_load,
  input  logic         cmd_snap,
  input  logic         cmd_stat_clr,
  input  logic         cmd_sign_set,
  input  logic         cmd_sign_clr,
  output logic [W-1:0] snap_q,
  output logic         st_carry,
  output logic         st_borrow,
  output logic         st_cmp,
  output logic         st_idx,
  output logic         sign_q,
  output logic         dir_up_q,
  output logic         count_active,
  output logic         flag_a_n,
  output logic         flag_b
);
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [1:0] M_FREE = 2'b00, M_ONCE = 2'b01, M_RANGE = 2'b10, M_MOD = 2'b11;

  logic [W-1:0] cnt_q, cnt_d;
  logic halted_q, idx_prev_q;
  logic [3:0] ev_q;
  logic ev_cy, ev_bw, ev_cmp, step;

  wire idx_edge = idx_prev_q & ~index_n;
  wire idx_hit  = idx_edge & (idx_func != 2'b00);
  wire do_clear = cmd_clear | (idx_edge & (idx_func == 2'b10));
  wire do_load  = ~do_clear & (cmd_load | (idx_edge & (idx_func == 2'b01)));
  wire do_snap  = cmd_snap | (idx_edge & (idx_func == 2'b11));
  wire req      = cnt_en & count_active & ~do_clear & ~do_load;
  wire at_top   = (cnt_q == data_reg);
  wire at_zero  = (cnt_q == ZERO);
  wire at_ones  = (cnt_q == ONES);

  assign count_active = ~cnt_inhibit & ~halted_q;

  always_comb begin
    cnt_d = cnt_q;
    ev_cy = 1'b0;
    ev_bw = 1'b0;
    step  = 1'b0;
    if (do_clear) cnt_d = ZERO;
    else if (do_load) cnt_d = data_reg;
    else if (req) begin
      case (cnt_mode)
        M_MOD: begin
          step = 1'b1;
          if (cnt_up) begin
            if (at_top) begin cnt_d = ZERO; ev_cy = 1'b1; end
            else cnt_d = cnt_q + 1'b1;
          end else begin
            if (at_zero) begin cnt_d = data_reg; ev_bw = 1'b1; end
            else cnt_d = cnt_q - 1'b1;
          end
        end
        M_RANGE: begin
          if (cnt_up && !at_top) begin cnt_d = cnt_q + 1'b1; step = 1'b1; end
          else if (!cnt_up && !at_zero) begin cnt_d = cnt_q - 1'b1; step = 1'b1; end
        end
        default: begin
          step = 1'b1;
          if (cnt_up) begin cnt_d = cnt_q + 1'b1; ev_cy = at_ones; end
          else begin cnt_d = cnt_q - 1'b1; ev_bw = at_zero; end
        end
      endcase
    end
  end

  assign ev_cmp = step & (cnt_d == data_reg) & (~cnt_mode[1] | cnt_up);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= ZERO;
      snap_q     <= ZERO;
      halted_q   <= 1'b0;
      idx_prev_q <= 1'b1;
      st_carry   <= 1'b0;
      st_borrow  <= 1'b0;
      st_cmp     <= 1'b0;
      st_idx     <= 1'b0;
      sign_q     <= 1'b0;
      dir_up_q   <= 1'b1;
      ev_q       <= 4'b0;
    end else begin
      cnt_q      <= cnt_d;
      idx_prev_q <= index_n;
      if (do_snap) snap_q <= cnt_q;
      if (do_clear || do_load) halted_q <= 1'b0;
      else if (cnt_mode == M_ONCE && (ev_cy || ev_bw)) halted_q <= 1'b1;
      st_carry  <= ev_cy   | (st_carry  & ~cmd_stat_clr);
      st_borrow <= ev_bw   | (st_borrow & ~cmd_stat_clr);
      st_cmp    <= ev_cmp  | (st_cmp    & ~cmd_stat_clr);
      st_idx    <= idx_hit | (st_idx    & ~cmd_stat_clr);
      if (ev_bw) sign_q <= 1'b1;
      else if (ev_cy) sign_q <= 1'b0;
      else if (cmd_sign_set) sign_q <= 1'b1;
      else if (cmd_sign_clr) sign_q <= 1'b0;
      if (cnt_en) dir_up_q <= cnt_up;
      ev_q <= {idx_hit, ev_cmp, ev_bw, ev_cy};
    end
  end

  wire [3:0] flag_src = flga_pulsed ? ev_q : {st_idx, st_cmp, st_borrow, st_carry};
  assign flag_a_n = ~|(flga_mask & flag_src);

  always_comb begin
    case (flgb_sel)
      2'b01:   flag_b = sign_q;
      2'b10:   flag_b = dir_up_q;
      default: flag_b = 1'b1;
    endcase
  end

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> (cnt_q == ZERO));
  p_load_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !cmd_clear && idx_func != 2'b10) |=> (cnt_q == $past(data_reg)));
  p_halt_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !cmd_clear && !cmd_load && idx_func == 2'b00) |=> $stable(cnt_q));
  p_range_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode == M_RANGE && at_top && cnt_up && !cmd_clear && !cmd_load && idx_func == 2'b00)
      |=> $stable(cnt_q));
  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inhibit && !cmd_clear && !cmd_load && idx_func == 2'b00) |=> $stable(cnt_q));
  p_carry_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_carry && !cmd_stat_clr) |=> st_carry);
endmodule

// File: tb/tb_pos_count_core.sv
module tb_pos_count_core;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0;
  logic cnt_en = 0, cnt_up = 0, cnt_inhibit = 0, flga_pulsed = 0, index_n = 1;
  logic [1:0] cnt_mode = 0, idx_func = 0, flgb_sel = 0;
  logic [3:0] flga_mask = 0;
  logic [31:0] data_reg = 0;
  logic cmd_clear = 0, cmd_load = 0, cmd_snap = 0, cmd_stat_clr = 0, cmd_sign_set = 0, cmd_sign_clr = 0;
  logic [31:0] snap_q;
  logic st_carry, st_borrow, st_cmp, st_idx, sign_q, dir_up_q, count_active, flag_a_n, flag_b;
  int checks = 0, errors = 0;
  logic [31:0] v;

  always #(CLK_P/2) clk = ~clk;

  pos_count_core #(.W(32)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic pulses(logic up, int n);
    for (int i = 0; i < n; i++) begin cnt_up = up; cnt_en = 1; cyc(); end
    cnt_en = 0;
  endtask

  task automatic read_cnt(output logic [31:0] r);
    cmd_snap = 1; cyc(); cmd_snap = 0; r = snap_q;
  endtask

  task automatic do_clear(); cmd_clear = 1; cyc(); cmd_clear = 0; endtask
  task automatic do_load(logic [31:0] d); data_reg = d; cmd_load = 1; cyc(); cmd_load = 0; endtask
  task automatic stat_clr(); cmd_stat_clr = 1; cyc(); cmd_stat_clr = 0; endtask
  task automatic idx_pulse(); index_n = 0; cyc(); index_n = 1; cyc(); endtask

  task automatic t_reset();
    chk("R1 snap", snap_q, 0);
    chk("R1 status", {st_carry, st_borrow, st_cmp, st_idx}, 0);
    chk("R1 sign/dir", {sign_q, dir_up_q}, 2'b01);
    chk("R1 active/flags", {count_active, flag_a_n, flag_b}, 3'b111);
    read_cnt(v); chk("R1 counter", v, 0);
  endtask

  task automatic t_free();
    cnt_mode = 2'b00; do_load(3); stat_clr();
    pulses(1, 2); read_cnt(v); chk("R2 up count", v, 5);
    pulses(0, 7); read_cnt(v); chk("R2 down wrap", v, 32'hFFFF_FFFE);
    chk("R2 borrow", st_borrow, 1); chk("R12 sign on borrow", sign_q, 1);
    chk("R6 compare down in free", st_cmp, 1);
    pulses(1, 2); read_cnt(v); chk("R2 up wrap", v, 0);
    chk("R2 carry", st_carry, 1); chk("R12 sign cleared by carry", sign_q, 0);
  endtask

  task automatic t_single();
    cnt_mode = 2'b01; do_load(1); stat_clr();
    pulses(0, 2); chk("R3 halted", count_active, 0);
    pulses(0, 3); read_cnt(v); chk("R3 frozen", v, 32'hFFFF_FFFF);
    do_clear(); chk("R3 re-enabled", count_active, 1);
    pulses(1, 1); read_cnt(v); chk("R3 counts after clear", v, 1);
  endtask

  task automatic t_range();
    cnt_mode = 2'b10; data_reg = 3; do_clear(); stat_clr();
    pulses(1, 5); read_cnt(v); chk("R4 top clamp", v, 3);
    chk("R6 compare up in range", st_cmp, 1);
    stat_clr(); pulses(1, 1); pulses(0, 5); read_cnt(v); chk("R4 zero clamp", v, 0);
    chk("R6 no compare down in range", st_cmp, 0);
    chk("R4 no borrow", st_borrow, 0);
    pulses(1, 1); read_cnt(v); chk("R4 resume", v, 1);
  endtask

  task automatic t_mod();
    cnt_mode = 2'b11; data_reg = 2; do_clear(); stat_clr();
    pulses(1, 3); read_cnt(v); chk("R5 up wrap", v, 0); chk("R5 carry", st_carry, 1);
    stat_clr(); pulses(0, 1); read_cnt(v); chk("R5 down wrap", v, 2);
    chk("R5 borrow", st_borrow, 1);
  endtask

  task automatic t_inhibit();
    cnt_mode = 2'b00; do_clear(); cnt_inhibit = 1; cyc();
    chk("R7 active low", count_active, 0);
    pulses(1, 4); read_cnt(v); chk("R7 blocked", v, 0);
    cnt_inhibit = 0; cyc();
  endtask

  task automatic t_index();
    data_reg = 9; do_clear(); stat_clr();
    idx_func = 2'b00; idx_pulse(); read_cnt(v); chk("R8 disabled", v, 0);
    chk("R8 disabled no status", st_idx, 0);
    idx_func = 2'b01; idx_pulse(); read_cnt(v); chk("R8 load", v, 9);
    chk("R8 status", st_idx, 1);
    data_reg = 4; index_n = 0; cyc(); cyc(); do_clear(); cyc(); index_n = 1; cyc();
    read_cnt(v); chk("R8 held low no repeat", v, 0);
    idx_func = 2'b10; do_load(9); idx_pulse(); read_cnt(v); chk("R8 clear", v, 0);
    idx_func = 2'b11; pulses(1, 2); idx_pulse(); chk("R8 snapshot", snap_q, 2);
    idx_func = 2'b00;
  endtask

  task automatic t_prio();
    cnt_mode = 2'b00; do_load(5);
    cmd_clear = 1; cmd_load = 1; cnt_en = 1; cnt_up = 1; cyc();
    cmd_clear = 0; cmd_load = 0; cnt_en = 0;
    read_cnt(v); chk("R9 clear beats load and count", v, 0);
    data_reg = 7; cmd_load = 1; cnt_en = 1; cyc(); cmd_load = 0; cnt_en = 0;
    read_cnt(v); chk("R9 load drops count", v, 7);
    cnt_en = 1; cmd_snap = 1; cyc(); cnt_en = 0; cmd_snap = 0;
    chk("R9 snapshot pre-count", snap_q, 7);
    read_cnt(v); chk("R9 count after snapshot", v, 8);
  endtask

  task automatic t_flaga();
    cnt_mode = 2'b00; flga_pulsed = 0; flga_mask = 4'b0001;
    do_load(32'hFFFF_FFFF); stat_clr();
    chk("R10 idle high", flag_a_n, 1);
    pulses(1, 1); chk("R10 latched low", flag_a_n, 0);
    cyc(); cyc(); chk("R10 latched holds", flag_a_n, 0);
    flga_mask = 4'b0010; cyc(); chk("R10 masked", flag_a_n, 1);
    flga_mask = 4'b0001; stat_clr(); chk("R10 released by clear", flag_a_n, 1);
    flga_pulsed = 1; do_load(32'hFFFF_FFFF);
    pulses(1, 1); chk("R10 pulse low", flag_a_n, 0);
    cyc(); chk("R10 pulse one cycle", flag_a_n, 1);
    flga_pulsed = 0; flga_mask = 0; stat_clr();
  endtask

  task automatic t_flagb();
    flgb_sel = 2'b00; cyc(); chk("R11 held high", flag_b, 1);
    flgb_sel = 2'b01; cmd_sign_clr = 1; cyc(); cmd_sign_clr = 0;
    chk("R11 sign low", flag_b, 0);
    cmd_sign_set = 1; cyc(); cmd_sign_set = 0; chk("R11 sign high", flag_b, 1);
    stat_clr(); chk("R12 status clear keeps sign", sign_q, 1);
    cmd_sign_clr = 1; cyc(); cmd_sign_clr = 0;
    do_clear(); cmd_sign_clr = 1; cnt_en = 1; cnt_up = 0; cyc();
    cmd_sign_clr = 0; cnt_en = 0;
    chk("R12 borrow beats sign clear", sign_q, 1);
    flgb_sel = 2'b10; pulses(0, 1); chk("R11 dir down", flag_b, 0);
    pulses(1, 1); chk("R11 dir up", flag_b, 1);
    flgb_sel = 2'b11; pulses(0, 1); chk("R11 code 11 high", flag_b, 1);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    t_reset(); t_free(); t_single(); t_range(); t_mod();
    t_inhibit(); t_index(); t_prio(); t_flaga(); t_flagb();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule